// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio for the feedback path of a phase-locked loop. Two coupled counters sit behind a prescaler with two moduli. A main counter B counts prescaler periods to set the length of one output cycle. A swallow counter A sets how many of those periods run at the longer modulus P+1. The total division is N = B·P + A input clocks. The block emits one pulse, one input clock wide, per output cycle.

A build-time parameter picks the band. The low band offers base moduli of 8 or 16, and the high band offers 64 or 32. A select bit supplied with each load chooses between the two moduli of the band. New A, B and select values are taken on a load strobe, but they only reach the counters at the next output-cycle boundary. A running cycle is therefore never cut short or lengthened. The block flags any loaded pair whose swallow count exceeds the main count, since such a pair cannot give an exact ratio.

Top module: `psd_divider`

## Requirements
- R1: While `rst` is high, `out_pulse` and `cfg_err` are 0. After reset the divider runs with A=0, B=1 and select 0, so the first full output interval is 1·P. For the default low band that is 8 input clocks.
- R2: `out_pulse` is high for exactly one input clock per output cycle. The spacing between successive pulses equals the active ratio N.
- R3: The base modulus P comes from the band parameter and the select bit. In the low band (`HIGH_BAND`=0), select 0 gives P=8 and select 1 gives P=16. In the high band, select 0 gives P=64 and select 1 gives P=32.
- R4: Within an output cycle, the first A prescaler periods last P+1 input clocks and the remaining B−A periods last P. For A ≤ B this gives N = B·P + A, and A=0 gives N = B·P.
- R5: When the active A exceeds the active B, every one of the B prescaler periods lasts P+1, so N = B·(P+1).
- R6: Values on `a_in` (6 bits), `b_in` (11 bits) and `sel_in` are captured on a clock where `ld` is high. They take effect from the first output-cycle boundary after that clock. The output interval during which the load happens keeps the previous ratio.
- R7: `cfg_err` updates only on a clock where `ld` is high. It goes to 1 when the loaded A is greater than the loaded B (after R8's substitution) and to 0 otherwise. It then holds its value until the next load.
- R8: A loaded B of 0 is treated as B=1.
- R9: The full range works, including B=2047 with A=63, which gives N = 2047·16 + 63 = 32815 in the low band with select 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ld | input | 1 | Load strobe for the new A, B and select values |
| a_in | input | 6 | Swallow count A (0 to 63) |
| b_in | input | 11 | Main count B (1 to 2047, 0 treated as 1) |
| sel_in | input | 1 | Prescaler modulus select within the band |
| out_pulse | output | 1 | One-clock pulse per N input clocks |
| cfg_err | output | 1 | Last loaded A exceeds last loaded B |

## Verification
Several properties are checked on every cycle. The pulse is never two clocks wide. The prescaler count stays within the largest modulus. Once the modulus control drops to P it stays there until the cycle ends. The active select changes only at a pulse, and the error flag changes only on a load. The exact spacing of the pulses can only be shown by the bench, which measures the intervals for a near-exhaustive sweep of small A and B values over both moduli, including A greater than B and B of zero. The bench also shows that the interval during which a load occurs keeps the old ratio, and it runs the extreme B=2047 settings.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int A_W     = 6;
    localparam int B_W     = 11;
    localparam int PC_W    = 7;
    localparam int MAX_MOD = 65;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           sel;
    } psd_cfg_t;

    function automatic logic [PC_W-1:0] base_mod(input logic high_band, input logic sel);
        if (!high_band) return sel ? PC_W'(16) : PC_W'(8);
        else            return sel ? PC_W'(32) : PC_W'(64);
    endfunction

    function automatic logic [B_W-1:0] fix_b(input logic [B_W-1:0] b);
        return (b == '0) ? B_W'(1) : b;
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter bit HIGH_BAND = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  logic            mod_ctl,
    output logic [PC_W-1:0] pcnt,
    output logic            pre_tick
);

    logic [PC_W-1:0] limit;

    always_comb begin
        limit    = base_mod(HIGH_BAND, sel) + PC_W'(mod_ctl);
        pre_tick = (pcnt == limit - PC_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)           pcnt <= '0;
        else if (pre_tick) pcnt <= '0;
        else               pcnt <= pcnt + PC_W'(1);
    end

endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_tick,
    input  logic [A_W-1:0] nxt_a,
    input  logic [B_W-1:0] nxt_b,
    output logic           mod_ctl,
    output logic           cyc_end
);

    logic [A_W-1:0] a_rem;
    logic [B_W-1:0] b_rem;

    always_comb begin
        mod_ctl = (a_rem != '0);
        cyc_end = pre_tick && (b_rem == B_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_rem <= '0;
            b_rem <= B_W'(1);
        end else if (pre_tick) begin
            if (b_rem == B_W'(1)) begin
                a_rem <= nxt_a;
                b_rem <= nxt_b;
            end else begin
                b_rem <= b_rem - B_W'(1);
                if (a_rem != '0) a_rem <= a_rem - A_W'(1);
            end
        end
    end

endmodule

// File: rtl/psd_cfg.sv
module psd_cfg
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           sel_in,
    input  logic           cyc_end,
    output psd_cfg_t       pend,
    output logic           act_sel,
    output logic           cfg_err
);

    logic [B_W-1:0] b_fixed;
    logic           bad_pair;

    always_comb begin
        b_fixed  = fix_b(b_in);
        bad_pair = {{(B_W-A_W){1'b0}}, a_in} > b_fixed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '{a: '0, b: B_W'(1), sel: 1'b0};
            cfg_err <= 1'b0;
        end else if (ld) begin
            pend    <= '{a: a_in, b: b_fixed, sel: sel_in};
            cfg_err <= bad_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          act_sel <= 1'b0;
        else if (cyc_end) act_sel <= pend.sel;
    end

endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
#(
    parameter bit HIGH_BAND = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           sel_in,
    output logic           out_pulse,
    output logic           cfg_err
);

    psd_cfg_t        pend;
    logic            act_sel;
    logic            mod_ctl;
    logic            pre_tick;
    logic            cyc_end;
    logic [PC_W-1:0] pcnt;

    psd_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld),
        .a_in    (a_in),
        .b_in    (b_in),
        .sel_in  (sel_in),
        .cyc_end (cyc_end),
        .pend    (pend),
        .act_sel (act_sel),
        .cfg_err (cfg_err)
    );

    psd_prescaler #(.HIGH_BAND(HIGH_BAND)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .sel      (act_sel),
        .mod_ctl  (mod_ctl),
        .pcnt     (pcnt),
        .pre_tick (pre_tick)
    );

    psd_swallow u_swl (
        .clk      (clk),
        .rst      (rst),
        .pre_tick (pre_tick),
        .nxt_a    (pend.a),
        .nxt_b    (pend.b),
        .mod_ctl  (mod_ctl),
        .cyc_end  (cyc_end)
    );

    assign out_pulse = cyc_end;

endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk
    import psd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ld,
    input logic            out_pulse,
    input logic            cfg_err,
    input logic            mod_ctl,
    input logic            act_sel,
    input logic [PC_W-1:0] pcnt
);

    AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        out_pulse |=> !out_pulse); // R2

    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        pcnt < PC_W'(MAX_MOD)); // R3

    AST_MC_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!mod_ctl && !out_pulse) |=> !mod_ctl); // R4

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_pulse |=> $stable(act_sel)); // R6

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(cfg_err)); // R7

endmodule

bind psd_divider psd_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld        (ld),
    .out_pulse (out_pulse),
    .cfg_err   (cfg_err),
    .mod_ctl   (mod_ctl),
    .act_sel   (act_sel),
    .pcnt      (pcnt)
);

// File: tb/sim_psd_divider.sv
module sim_psd_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld = 1'b0;
    logic [5:0]  a_in = '0;
    logic [10:0] b_in = '0;
    logic        sel_in = 1'b0;
    logic        out_pulse;
    logic        cfg_err;

    int errs   = 0;
    int checks = 0;
    int cur_n  = 8;

    always #2.5 clk = ~clk;

    psd_divider u0 (
        .clk       (clk),
        .rst       (rst),
        .ld        (ld),
        .a_in      (a_in),
        .b_in      (b_in),
        .sel_in    (sel_in),
        .out_pulse (out_pulse),
        .cfg_err   (cfg_err)
    );

    function automatic int eff_b(input int b);
        return (b == 0) ? 1 : b;
    endfunction

    function automatic int expect_n(input int a, input int b, input int sel);
        int bb = eff_b(b);
        int p  = sel ? 16 : 8;
        if (a > bb) return bb * (p + 1);
        return bb * p + a;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!out_pulse);
    endtask

    // Called at a negedge where out_pulse is high.
    task automatic run_cfg(input int a, input int b, input int sel, input string req);
        int n;
        int n2;
        int exp_err;
        exp_err = (a > eff_b(b)) ? 1 : 0;
        @(negedge clk);
        n = 1;
        chk("R2 pulse width", int'(out_pulse), 0);
        ld     = 1'b1;
        a_in   = 6'(a);
        b_in   = 11'(b);
        sel_in = sel[0];
        @(negedge clk);
        n = 2;
        ld = 1'b0;
        chk("R7 flag after load", int'(cfg_err), exp_err);
        while (!out_pulse) begin
            @(negedge clk);
            n++;
        end
        chk("R6 interval holding load", n, cur_n);
        cur_n = expect_n(a, b, sel);
        gap(n2);
        chk(req, n2, cur_n);
        chk("R7 flag held", int'(cfg_err), exp_err);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk("R1 pulse in reset", int'(out_pulse), 0);
        chk("R1 flag in reset", int'(cfg_err), 0);
        rst = 1'b0;
        gap(n);
        gap(n);
        chk("R1 default interval", n, 8);

        for (int s = 0; s < 2; s++) begin
            for (int b = 1; b <= 4; b++) begin
                for (int a = 0; a <= b + 1; a++) begin
                    if (a > b) run_cfg(a, b, s, "R5 swallow beyond B");
                    else       run_cfg(a, b, s, "R3/R4 ratio B*P+A");
                end
            end
        end

        run_cfg(0, 0, 0, "R8 zero B");
        run_cfg(1, 0, 1, "R8 zero B with A=1");
        run_cfg(5, 0, 0, "R8 zero B flagged");
        run_cfg(63, 2047, 1, "R9 max B and A");
        run_cfg(0, 2047, 0, "R9 max B, A=0");
        run_cfg(2, 3, 0, "R4 after max");
        report();
    end

endmodule